// File: doc/BRIEF.md
# Selectable-Source Error Rate Counter

This block measures how often a chosen kind of error event occurs in a decoded data stream. Four single-cycle error pulses arrive side by side. A select input picks the one that feeds a 16-bit counter, and the count is offered to a register interface as a low byte and a high byte.

In windowed mode a byte-strobe counter marks out measurement windows of a selectable number of output bytes. At the end of each window the count moves into a holding register, and counting starts over. In live mode the readable value follows the counter directly, and reading the high byte clears the counter. In both modes the counter stops at its largest value instead of wrapping. Reading the high byte captures the low byte in a shadow register, so a high-then-low byte pair describes one instant.

Top module: `err_rate_counter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the counter, the holding register and the shadow register are zero, and both read bytes show 0.
- R2: On each clock edge, only the event bit `err_evt[src_sel]` adds to the counter (index 0 to 3). Pulses on the other three bits have no effect.
- R3: In windowed mode (`mode`=0), a window lasts 2^(WIN_BASE_LOG2 + WIN_STEP_LOG2*`win_sel`) byte strobes. With the defaults this is 2^12, 2^14, 2^16 or 2^18 bytes. On the edge that takes the last strobe, the count so far moves into the holding register and the counter restarts.
- R4: In windowed mode, the read bytes show the holding register (high byte `rd_data_hi`, low byte `rd_data_lo`). It changes only at a window end.
- R5: In live mode (`mode`=1), the read bytes show the counter itself. An event counted at an edge is visible from that edge on.
- R6: In live mode, a cycle with `rd_hi` high clears the counter at the next edge.
- R7: In either mode, the counter stays at 0xFFFF when further events arrive and does not wrap.
- R8: A cycle with `rd_hi` high captures the low byte then on view. The next `rd_data_lo` read returns that captured byte. A cycle with `rd_lo` high and `rd_hi` low releases the capture, and the low byte follows the view again from the next edge. A low-byte read with no high-byte read before it returns the current low byte.
- R9: An event that falls on the same edge as a restart (window end or live clear) is counted in the new period: the counter becomes 1.
- R10: In windowed mode, byte reads do not clear or change the counter. Byte strobes in live mode do not advance the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 4 | One error-event pulse per source |
| src_sel | input | 2 | Selects the source that is counted |
| mode | input | 1 | 0 = windowed, 1 = live with clear on high-byte read |
| win_sel | input | 2 | Selects the window length in output bytes |
| byte_stb | input | 1 | One pulse per output byte |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data_lo | output | 8 | Low byte of the readable count |
| rd_data_hi | output | 8 | High byte of the readable count |

## Verification
Events are driven on all four sources at once with patterns that differ per source, so a mis-indexed select gives a count from the wrong bit. Windowed runs use gapped byte strobes at every window length and place events on the closing strobe. These show whether the length decode is right, whether the hold transfer happens on the correct edge, and whether a boundary event lands in the new window. Live runs mix high-then-low reads with events between the two reads, which separates a coherent shadow from a direct low byte. A long constant event train separates saturation from wrap-around.

// File: rtl/errc_pkg.sv
package errc_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_LIVE   = 1'b1
    } errc_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } errc_word_t;

    function automatic int unsigned win_log2(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned sel);
        return base + step * sel;
    endfunction

endpackage

// File: rtl/errc_src_mux.sv
module errc_src_mux #(
    parameter int unsigned NSRC  = 4,
    parameter int unsigned SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  evt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (sel == SEL_W'(k)) hit = evt[k];
        end
    end
endmodule

// File: rtl/errc_window.sv
module errc_window
    import errc_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned NWIN      = 4,
    parameter int unsigned SEL_W     = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             byte_stb,
    input  logic [SEL_W-1:0] win_sel,
    output logic             win_end
);
    localparam int unsigned MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * (NWIN - 1);

    logic [MAX_LOG2-1:0] bcnt_q;
    logic [MAX_LOG2-1:0] last_idx [NWIN];
    logic [MAX_LOG2-1:0] sel_last;

    for (genvar k = 0; k < NWIN; k++) begin : g_lim
        assign last_idx[k] = {MAX_LOG2{1'b1}} >>
                             (MAX_LOG2 - win_log2(BASE_LOG2, STEP_LOG2, k));
    end

    always_comb begin
        sel_last = last_idx[0];
        for (int k = 0; k < NWIN; k++) begin
            if (win_sel == SEL_W'(k)) sel_last = last_idx[k];
        end
    end

    assign win_end = enable && byte_stb && (bcnt_q >= sel_last);

    always_ff @(posedge clk) begin
        if (rst || !enable) bcnt_q <= '0;
        else if (win_end)   bcnt_q <= '0;
        else if (byte_stb)  bcnt_q <= bcnt_q + 1'b1;
    end
endmodule

// File: rtl/errc_sat_counter.sv
module errc_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    logic at_max;
    assign at_max = &cnt;

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (restart)         cnt <= W'(inc);
        else if (inc && !at_max)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/errc_readout.sv
module errc_readout
    import errc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  errc_mode_e        mode,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              win_end,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [CNT_W-1:0]  view,
    output logic [BYTE_W-1:0] rd_data_lo,
    output logic [BYTE_W-1:0] rd_data_hi
);
    logic [CNT_W-1:0]  hold_q;
    logic [BYTE_W-1:0] shadow_q;
    logic              shadow_v_q;
    errc_word_t        vw;

    assign view = (mode == MODE_LIVE) ? cnt : hold_q;
    assign vw   = errc_word_t'(view);

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (win_end) hold_q <= cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            shadow_v_q <= 1'b0;
        end else if (rd_hi) begin
            shadow_q   <= vw.lo;
            shadow_v_q <= 1'b1;
        end else if (rd_lo) begin
            shadow_v_q <= 1'b0;
        end
    end

    assign rd_data_hi = vw.hi;
    assign rd_data_lo = shadow_v_q ? shadow_q : vw.lo;
endmodule

// File: rtl/err_rate_counter.sv
module err_rate_counter
    import errc_pkg::*;
#(
    parameter int unsigned NSRC          = 4,
    parameter int unsigned NWIN          = 4,
    parameter int unsigned WIN_BASE_LOG2 = 12,
    parameter int unsigned WIN_STEP_LOG2 = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         err_evt,
    input  logic [$clog2(NSRC)-1:0] src_sel,
    input  logic                    mode,
    input  logic [$clog2(NWIN)-1:0] win_sel,
    input  logic                    byte_stb,
    input  logic                    rd_lo,
    input  logic                    rd_hi,
    output logic [7:0]              rd_data_lo,
    output logic [7:0]              rd_data_hi
);
    errc_mode_e       mode_e;
    logic             inc;
    logic             win_end;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] view;

    assign mode_e  = errc_mode_e'(mode);
    assign restart = (mode_e == MODE_LIVE) ? rd_hi : win_end;

    errc_src_mux #(.NSRC(NSRC)) u_mux (
        .evt (err_evt),
        .sel (src_sel),
        .hit (inc)
    );

    errc_window #(
        .BASE_LOG2 (WIN_BASE_LOG2),
        .STEP_LOG2 (WIN_STEP_LOG2),
        .NWIN      (NWIN)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .enable   (mode_e == MODE_WINDOW),
        .byte_stb (byte_stb),
        .win_sel  (win_sel),
        .win_end  (win_end)
    );

    errc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .restart (restart),
        .cnt     (cnt)
    );

    errc_readout u_rd (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .cnt        (cnt),
        .win_end    (win_end),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .view       (view),
        .rd_data_lo (rd_data_lo),
        .rd_data_hi (rd_data_hi)
    );
endmodule

// File: rtl/errc_checker.sv
module errc_checker (
    input logic        clk,
    input logic        rst,
    input logic        mode,
    input logic        rd_hi,
    input logic        inc,
    input logic        restart,
    input logic [15:0] cnt,
    input logic [15:0] view,
    input logic [7:0]  rd_data_lo
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt == 16'd0 && view == 16'd0 && rd_data_lo == 8'd0));

    // R7: never decreases without a restart, so it cannot wrap
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !restart |=> cnt >= $past(cnt));

    // R9: event on a restart edge opens the new period with one count
    a_r9_restart_value: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == 16'($past(inc)));

    // R4: held value only moves at a window end
    a_r4_hold_still: assert property (@(posedge clk) disable iff (rst)
        (!mode && !restart) |=> (mode || $stable(view)));

    // R6
    a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (mode && rd_hi) |=> cnt <= 16'd1);

    // R8
    a_r8_shadow_coherent: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> rd_data_lo == $past(view[7:0]));
endmodule

bind err_rate_counter errc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .rd_hi      (rd_hi),
    .inc        (inc),
    .restart    (restart),
    .cnt        (cnt),
    .view       (view),
    .rd_data_lo (rd_data_lo)
);

// File: tb/err_rate_counter_bench.sv
module err_rate_counter_bench;
    localparam int BASE = 3;
    localparam int STEP = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] err_evt = '0;
    logic [1:0] src_sel = '0;
    logic       mode = 1'b0;
    logic [1:0] win_sel = '0;
    logic       byte_stb = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data_lo;
    logic [7:0] rd_data_hi;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_hold = 0, m_bc = 0, m_sh = 0;
    bit m_shv = 0;

    always #10 clk = ~clk;

    err_rate_counter #(.WIN_BASE_LOG2(BASE), .WIN_STEP_LOG2(STEP)) u_err_rate_counter (
        .clk(clk), .rst(rst), .err_evt(err_evt), .src_sel(src_sel),
        .mode(mode), .win_sel(win_sel), .byte_stb(byte_stb),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi)
    );

    function automatic int view_val();
        return mode ? m_cnt : m_hold;
    endfunction

    task automatic model_edge();
        int  len;
        bit  inc, wend, restart;
        int  v;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_bc = 0; m_sh = 0; m_shv = 0;
            return;
        end
        len  = 1 << (BASE + STEP * int'(win_sel));
        inc  = err_evt[src_sel];
        wend = !mode && byte_stb && (m_bc >= len - 1);
        restart = mode ? rd_hi : wend;
        v = view_val();
        if (rd_hi) begin m_sh = v & 255; m_shv = 1; end
        else if (rd_lo) m_shv = 0;
        if (wend) m_hold = m_cnt;
        if (restart) m_cnt = inc ? 1 : 0;
        else if (inc && m_cnt < 65535) m_cnt = m_cnt + 1;
        if (mode) m_bc = 0;
        else if (wend) m_bc = 0;
        else if (byte_stb) m_bc = m_bc + 1;
    endtask

    task automatic compare();
        int v, e_hi, e_lo;
        v = view_val();
        e_hi = v >> 8;
        e_lo = m_shv ? m_sh : (v & 255);
        n_checks++;
        if (int'(rd_data_hi) != e_hi || int'(rd_data_lo) != e_lo) begin
            n_fail++;
            $display("FAIL %s: hi/lo got %0d/%0d expected %0d/%0d",
                     cur_req, rd_data_hi, rd_data_lo, e_hi, e_lo);
        end
    endtask

    task automatic step(input logic [3:0] e, input logic [1:0] s, input logic m,
                        input logic [1:0] w, input logic b, input logic rl, input logic rh);
        err_evt = e; src_sel = s; mode = m; win_sel = w;
        byte_stb = b; rd_lo = rl; rd_hi = rh;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        step(4'hF, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        step(4'hF, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        rst = 1'b0;
        step(4'h0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);

        // R2 and R5: each source with distinct patterns on all bits, live mode
        for (int s = 0; s < 4; s++) begin
            cur_req = "R2";
            for (int k = 0; k < 20; k++)
                step(4'((k * 5 + s) ^ (k >> 1)), 2'(s), 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
            cur_req = "R5";
            step(4'h0, 2'(s), 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
            // R6 clear via high-byte read, then R8 release
            cur_req = "R6";
            step(4'h0, 2'(s), 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
            step(4'h0, 2'(s), 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        end

        // R8: high read, events in between, then low read
        cur_req = "R8";
        for (int k = 0; k < 300; k++)
            step(4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        step(4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++)
            step(4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        step(4'b0000, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        step(4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        // R9: event on the live clear edge
        cur_req = "R9";
        step(4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        step(4'b0000, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        step(4'b0000, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);

        // R3, R4, R9, R10: windowed mode at every length, gapped strobes
        for (int w = 0; w < 4; w++) begin
            cur_req = (w % 2 == 0) ? "R3" : "R4";
            step(4'h0, 2'd1, 1'b1, 2'(w), 1'b0, 1'b0, 1'b1);
            step(4'h0, 2'd1, 1'b0, 2'(w), 1'b0, 1'b1, 1'b0);
            for (int k = 0; k < (3 << (BASE + STEP * w)) + 40; k++) begin
                if (k % 17 == 5) cur_req = "R10";
                else if (k % 17 == 0) cur_req = "R9";
                else cur_req = "R3";
                step(4'((k * 3) ^ (k >> 2)), 2'd1, 1'b0, 2'(w), 1'((k % 3) != 1),
                     1'(k % 17 == 6), 1'(k % 17 == 5));
            end
            // event exactly on closing strobes
            cur_req = "R9";
            for (int k = 0; k < (2 << (BASE + STEP * w)); k++)
                step(4'b0010, 2'd1, 1'b0, 2'(w), 1'b1, 1'b0, 1'b0);
        end

        // R10: strobes in live mode do not advance the window
        cur_req = "R10";
        for (int k = 0; k < 20; k++)
            step(4'h0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 12; k++)
            step(4'h1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);

        // R7: saturation in live mode
        cur_req = "R7";
        step(4'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        step(4'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 65545; k++)
            step(4'h8, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        step(4'h8, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        step(4'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        step(4'h0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule